// File: doc/BRIEF.md
# Fixed-Point Matrix-Vector Multiply-Add Unit

This unit transforms a three-component signed vector by a signed 3x3 matrix and adds a signed translation vector. All values are fixed point. Each row sum is built in a 64-bit accumulator. The accumulator is seeded with the row's translation component scaled up by 4096, so that translation and products share one binary point. A per-operation select bit can then drop twelve fraction bits with an arithmetic right shift.

An operation is offered on a valid/ready input channel. The unit takes the request only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is high exactly while the unit is idle, so a request offered while busy is stalled, and any change to it during that time goes unseen. The output side has no back-pressure. `done_o` pulses for one cycle when the three results and the flag word are all valid, and these outputs then hold until the next completion.

A single 16x16 multiplier is shared, giving one product per cycle. Rows are handled in the order 1, 2, 3. While a row is finished, its 64-bit sum is tested against the signed 32-bit range. Each overflow sets a fixed bit in the status word.

Top module: `mvmac_unit`

## Requirements
- R1: Matrix elements are packed in `mat_i` as nine signed 16-bit halfwords in row-major order, with element (1,1) in bits [15:0] and element (3,3) in bits [143:128]. Vector components sit in `vec_i`, with x in [15:0], y in [31:16] and z in [47:32]. Translation row r (r = 1..3) sits in `tr_i[32r-1:32r-32]`.
- R2: With `shift_i` low, result row r is the low 32 bits of (sign-extended translation r times 4096) plus Mr1·x + Mr2·y + Mr3·z, computed in 64 bits. Row 1 is in `res_o[31:0]`, row 2 in [63:32] and row 3 in [95:64].
- R3: With `shift_i` high, the 64-bit row sum is shifted arithmetically right by 12 before both the result and the overflow test are taken.
- R4: A row sum above 2^31-1 sets flag bit 30 for row 1, bit 29 for row 2 and bit 28 for row 3.
- R5: A row sum below -2^31 sets flag bit 27 for row 1, bit 26 for row 2 and bit 25 for row 3. It also sets bit 31.
- R6: With `flag_en_i` low, `flag_o` is all zeros whatever the arithmetic gives.
- R7: Flag bit 0 is never set.
- R8: `done_o` rises exactly 9 clock edges after the accepting edge and is high for one cycle.
- R9: `in_ready` is low from the accepting edge until `done_o` rises. A request offered in that time is not taken and does not alter the results.
- R10: `res_o` and `flag_o` change only at the edge that raises `done_o`, and hold between completions. After reset they are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit idle and able to take a request |
| mat_i | input | 144 | Nine signed 16-bit matrix elements, row-major |
| vec_i | input | 48 | Signed 16-bit x, y, z |
| tr_i | input | 96 | Three signed 32-bit translation components |
| shift_i | input | 1 | Shift row sums right by 12 |
| flag_en_i | input | 1 | Enable overflow flag reporting |
| res_o | output | 96 | Three 32-bit row results |
| flag_o | output | 32 | Overflow status word |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A request is taken on a rising edge. The results, flags and `done_o` all arrive together, nine edges later. No output is due at any earlier point. The bench drives inputs on falling edges and samples outputs on falling edges. After the accepting edge it counts edges up to `done_o` and compares that count with nine. In every cycle before `done_o` it also confirms that `res_o` and `flag_o` have not moved. A request offered mid-operation is checked to see that it neither raises `in_ready` nor disturbs the results that follow.

// File: rtl/mvmac_pkg.sv
package mvmac_pkg;
  localparam int EW    = 16;
  localparam int RW    = 32;
  localparam int AW    = 64;
  localparam int SH    = 12;
  localparam int ROWS  = 3;
  localparam int COLS  = 3;
  localparam int FW    = 32;
  localparam int SUM_NEG_BIT = 31;

  function automatic int pos_bit(input int r);
    return 30 - r;
  endfunction

  function automatic int neg_bit(input int r);
    return 27 - r;
  endfunction
endpackage

// File: rtl/mvmac_ctrl.sv
module mvmac_ctrl #(
  parameter int ROWS = 3,
  parameter int COLS = 3,
  localparam int RBW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CBW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic [RBW-1:0] row,
  output logic [CBW-1:0] col,
  output logic           col_first,
  output logic           col_last,
  output logic           op_last,
  output logic           done
);
  assign col_first = (col == '0);
  assign col_last  = (col == CBW'(COLS-1));
  assign op_last   = col_last && (row == RBW'(ROWS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      row  <= '0;
      col  <= '0;
      done <= 1'b0;
    end else begin
      done <= busy && op_last;
      if (start) begin
        busy <= 1'b1;
        row  <= '0;
        col  <= '0;
      end else if (busy) begin
        if (col_last) begin
          col <= '0;
          if (op_last) begin
            busy <= 1'b0;
            row  <= '0;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R9
endmodule

// File: rtl/mvmac_mul.sv
module mvmac_mul #(
  parameter int EW = 16
) (
  input  logic signed [EW-1:0]   a,
  input  logic signed [EW-1:0]   b,
  output logic signed [2*EW-1:0] p
);
  assign p = a * b;
endmodule

// File: rtl/mvmac_acc.sv
module mvmac_acc #(
  parameter int EW = 16,
  parameter int RW = 32,
  parameter int AW = 64,
  parameter int SH = 12,
  localparam int PW = 2*EW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic                 shift,
  input  logic signed [RW-1:0] tr,
  input  logic signed [PW-1:0] prod,
  output logic        [RW-1:0] res,
  output logic                 ovf_pos,
  output logic                 ovf_neg
);
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (RW-1)) - 64'sd1);
  localparam logic signed [AW-1:0] MINV = -(AW'(64'sd1 <<< (RW-1)));

  logic signed [AW-1:0] acc_q, base, sum, fin;

  always_comb begin
    if (first) base = {{(AW-RW){tr[RW-1]}}, tr} <<< SH;
    else       base = acc_q;
    sum = base + {{(AW-PW){prod[PW-1]}}, prod};
    fin = shift ? (sum >>> SH) : sum;
  end

  assign res     = fin[RW-1:0];
  assign ovf_pos = fin > MAXV;
  assign ovf_neg = fin < MINV;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= sum;
  end

  AST_OVF_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ovf_pos && ovf_neg)); // R4
endmodule

// File: rtl/mvmac_unit.sv
module mvmac_unit
  import mvmac_pkg::*;
#(
  parameter int EW_P = EW,
  parameter int RW_P = RW,
  parameter int AW_P = AW,
  parameter int SH_P = SH,
  localparam int NM = ROWS*COLS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NM*EW_P-1:0]     mat_i,
  input  logic [COLS*EW_P-1:0]   vec_i,
  input  logic [ROWS*RW_P-1:0]   tr_i,
  input  logic                   shift_i,
  input  logic                   flag_en_i,
  output logic [ROWS*RW_P-1:0]   res_o,
  output logic [FW-1:0]          flag_o,
  output logic                   done_o
);
  localparam int RBW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CBW = (COLS > 1) ? $clog2(COLS) : 1;

  logic                 busy, col_first, col_last, op_last, start;
  logic [RBW-1:0]       row;
  logic [CBW-1:0]       col;
  logic [NM*EW_P-1:0]   mat_q;
  logic [COLS*EW_P-1:0] vec_q;
  logic [ROWS*RW_P-1:0] tr_q;
  logic                 sh_q, fe_q;
  logic signed [EW_P-1:0]   m_sel, v_sel;
  logic signed [RW_P-1:0]   t_sel;
  logic signed [2*EW_P-1:0] prod;
  logic [RW_P-1:0]      row_res;
  logic                 ovf_pos, ovf_neg;
  logic [RW_P-1:0]      wres [ROWS];
  logic [FW-1:0]        wflag, row_bits;

  assign in_ready = !busy;
  assign start    = in_valid && in_ready;

  mvmac_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .row(row), .col(col),
    .col_first(col_first), .col_last(col_last), .op_last(op_last), .done(done_o)
  );

  always_comb begin
    m_sel = mat_q[EW_P*(int'(row)*COLS + int'(col)) +: EW_P];
    v_sel = vec_q[EW_P*int'(col) +: EW_P];
    t_sel = tr_q[RW_P*int'(row) +: RW_P];
  end

  mvmac_mul #(.EW(EW_P)) u_mul (.a(m_sel), .b(v_sel), .p(prod));

  mvmac_acc #(.EW(EW_P), .RW(RW_P), .AW(AW_P), .SH(SH_P)) u_acc (
    .clk(clk), .rst_n(rst_n), .en(busy), .first(col_first), .shift(sh_q),
    .tr(t_sel), .prod(prod), .res(row_res), .ovf_pos(ovf_pos), .ovf_neg(ovf_neg)
  );

  always_comb begin
    row_bits = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (int'(row) == r) begin
        if (ovf_pos) row_bits[pos_bit(r)] = 1'b1;
        if (ovf_neg) begin
          row_bits[neg_bit(r)]   = 1'b1;
          row_bits[SUM_NEG_BIT]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mat_q <= '0;
      vec_q <= '0;
      tr_q  <= '0;
      sh_q  <= 1'b0;
      fe_q  <= 1'b0;
      wflag <= '0;
    end else if (start) begin
      mat_q <= mat_i;
      vec_q <= vec_i;
      tr_q  <= tr_i;
      sh_q  <= shift_i;
      fe_q  <= flag_en_i;
      wflag <= '0;
    end else if (busy && col_last) begin
      wflag <= wflag | row_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else if (busy && op_last)
      flag_o <= fe_q ? ((wflag | row_bits) & ~FW'(1)) : '0;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wres[r] <= '0;
        res_o[RW_P*r +: RW_P] <= '0;
      end else if (busy && col_last) begin
        if (int'(row) == r) wres[r] <= row_res;
        if (op_last)
          res_o[RW_P*r +: RW_P] <= (int'(row) == r) ? row_res : wres[r];
      end
    end
  end

  AST_HOLD_RES: assert property (@(posedge clk) disable iff (!rst_n) !$stable(res_o) |-> done_o); // R10
  AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !$stable(flag_o) |-> done_o); // R10
  AST_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !fe_q) |-> (flag_o == '0)); // R6
  AST_BIT0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !flag_o[0]); // R7
  AST_NEG_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n) (done_o && |flag_o[27:25]) |-> flag_o[31]); // R5
  AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (busy && !op_last) |=> busy); // R9
endmodule

// File: tb/sim_mvmac_unit.sv
module sim_mvmac_unit;
  typedef struct packed {
    logic [143:0] mat;
    logic [47:0]  vec;
    logic [95:0]  tr;
    logic         sh;
    logic         fe;
  } op_t;

  localparam int NV = 6;
  localparam op_t TBL [NV] = '{
    // general mix, no shift (R1, R2)
    '{ {16'd9,16'hFFF8,16'd7,16'd6,16'd5,16'hFFFC,16'd3,16'd2,16'd1},
       {16'd5,16'hFFFC,16'd3}, {32'd10,32'hFFFFFFFF,32'd7}, 1'b0, 1'b1 },
    // identity*4096 with shift (R3)
    '{ {16'h1000,16'd0,16'd0,16'd0,16'h1000,16'd0,16'd0,16'd0,16'h1000},
       {16'd5,16'hFFFC,16'd3}, {32'd3,32'd2,32'd1}, 1'b1, 1'b1 },
    // row1 positive, row2 negative overflow (R4, R5)
    '{ 144'd0, 48'd0, {32'd0,32'h80000000,32'h7FFFFFFF}, 1'b0, 1'b1 },
    // same with flags disabled (R6)
    '{ 144'd0, 48'd0, {32'd0,32'h80000000,32'h7FFFFFFF}, 1'b0, 1'b0 },
    // all rows positive overflow after shift (R4)
    '{ {9{16'h8000}}, {3{16'h8000}}, {3{32'h7FFFFFFF}}, 1'b1, 1'b1 },
    // all rows negative overflow after shift (R5, R7)
    '{ {9{16'h7FFF}}, {3{16'h8000}}, {3{32'h80000000}}, 1'b1, 1'b1 }
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, shift_i = 1'b0, flag_en_i = 1'b0;
  logic [143:0] mat_i = '0;
  logic [47:0]  vec_i = '0;
  logic [95:0]  tr_i = '0;
  logic in_ready, done_o;
  logic [95:0] res_o;
  logic [31:0] flag_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mvmac_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mat_i(mat_i), .vec_i(vec_i), .tr_i(tr_i), .shift_i(shift_i),
    .flag_en_i(flag_en_i), .res_o(res_o), .flag_o(flag_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input op_t o, output logic [95:0] r, output logic [31:0] f);
    f = '0;
    for (int row = 0; row < 3; row++) begin
      int t = o.tr[32*row +: 32];
      longint acc = longint'(t) <<< 12;
      for (int c = 0; c < 3; c++) begin
        shortint a = o.mat[16*(3*row+c) +: 16];
        shortint b = o.vec[16*c +: 16];
        acc += longint'(a) * longint'(b);
      end
      if (o.sh) acc = acc >>> 12;
      if (acc > 64'sd2147483647) f[30-row] = 1'b1;
      if (acc < -64'sd2147483648) begin
        f[27-row] = 1'b1;
        f[31] = 1'b1;
      end
      r[32*row +: 32] = acc[31:0];
    end
    if (!o.fe) f = '0;
  endfunction

  // Offers o, waits for done; optionally offers a different request while busy.
  task automatic run_op(input op_t o, input bit poke, output int lat);
    logic [95:0] r0;
    logic [31:0] f0;
    bit held = 1'b1;
    @(negedge clk);
    mat_i = o.mat; vec_i = o.vec; tr_i = o.tr; shift_i = o.sh; flag_en_i = o.fe;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    r0 = res_o; f0 = flag_o;
    lat = 0;
    while (!done_o && lat < 40) begin
      if (res_o !== r0 || flag_o !== f0) held = 1'b0;
      if (poke && lat == 3) begin
        check("R9 ready low while busy", 128'(in_ready), 128'(0));
        mat_i = ~o.mat; vec_i = ~o.vec; tr_i = ~o.tr; shift_i = ~o.sh; flag_en_i = ~o.fe;
        in_valid = 1'b1;
      end
      if (poke && lat == 5) in_valid = 1'b0;
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    check("R10 outputs held during run", 128'(held), 128'(1));
  endtask

  initial begin
    #(4*200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [95:0] er;
    logic [31:0] ef;
    int lat;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset res", 128'(res_o), 128'(0));
    check("R10 reset flag", 128'(flag_o), 128'(0));
    check("R8 reset done", 128'(done_o), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready idle", 128'(in_ready), 128'(1));

    for (int i = 0; i < NV; i++) begin
      run_op(TBL[i], 1'b0, lat);
      model(TBL[i], er, ef);
      check("R8 latency", 128'(lat), 128'(9));
      check("R1 R2 R3 results", 128'(res_o), 128'(er));
      check("R4 R5 R6 flags", 128'(flag_o), 128'(ef));
      check("R7 bit0", 128'(flag_o[0]), 128'(0));
      @(negedge clk);
      check("R8 done one cycle", 128'(done_o), 128'(0));
    end

    // Hand-derived corner values
    run_op(TBL[1], 1'b0, lat);
    check("R3 shifted identity", 128'(res_o), 128'({32'd8, 32'hFFFFFFFE, 32'd4}));
    run_op(TBL[2], 1'b0, lat);
    check("R4 R5 fixed flag bits", 128'(flag_o), 128'(32'hC4000000));
    check("R2 wrapped low word", 128'(res_o), 128'({32'd0, 32'd0, 32'hFFFFF000}));
    run_op(TBL[4], 1'b0, lat);
    check("R4 all rows positive", 128'(flag_o), 128'(32'h70000000));
    run_op(TBL[5], 1'b0, lat);
    check("R5 all rows negative", 128'(flag_o), 128'(32'h8E000000));

    // R9: request during busy is ignored
    run_op(TBL[0], 1'b1, lat);
    model(TBL[0], er, ef);
    check("R9 results unaffected", 128'(res_o), 128'(er));
    check("R8 latency with poke", 128'(lat), 128'(9));
    begin
      bit extra = 1'b0;
      for (int k = 0; k < 14; k++) begin
        @(negedge clk);
        if (done_o) extra = 1'b1;
      end
      check("R9 no second completion", 128'(extra), 128'(0));
      check("R10 hold after done", 128'(res_o), 128'(er));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule